// File: doc/BRIEF.md
# Indirect Multiplexed GPIO Controller

This block controls 22 general-purpose pins arranged in three groups: an eight-pin group numbered 10 to 17, a six-pin group numbered 20 to 25, and an eight-pin group numbered 30 to 37. It has two byte-wide access paths. The setup path holds a relocation register and one setup byte per pin. The I/O path reaches pin data through an index/data port pair. The relocation register enables the pair and chooses its address.

Each pin's setup byte picks its direction and polarity. It can also hand the pin to an alternate-function peripheral. In that case the pad takes its drive and enable from the peripheral's signals instead of the data latch. Pad inputs pass through a synchronizer. The synchronized levels feed the alternate-function peripherals and the data readback. Read data and pad drive are both registered.

Top module: `gmux_gpio`

## Requirements
- R1: Reset behaviour. After a synchronous reset:
  - every pin setup byte reads 0x01, so every pin is an input;
  - the relocation register reads 0x00;
  - all pad enables, all pad outputs and both read-data ports are 0;
  - the data latches and the index register are 0.
- R2: Relocation register (setup address 0x03). Bit 7 enables the index/data pair. Bits 1:0 choose the index/data address pair: 0 gives 0xE0/0xE1, 1 gives 0xE2/0xE3, 2 gives 0xE4/0xE5, and 3 gives 0xEA/0xEB. Bits 6:2 read as 0.
- R3: Disabled pair. While bit 7 of the relocation register is 0:
  - I/O writes change nothing;
  - every I/O read returns 0xFF.
  While the pair is enabled, an I/O read of any address outside the pair also returns 0xFF.
- R4: Index register and data mapping.
  - A read of the index address returns the last index written.
  - At the data address, index 0x01 selects pins 10–17, index 0x02 selects pins 20–25, and index 0x03 selects pins 30–37. Pin n sits at bit (n mod 10).
  - With any other index, a data read returns 0x00 and a data write has no effect.
- R5: For index 0x02, data bits 7:6 always read 0, and writing them has no effect.
- R6: Setup byte addresses:
  - pins 10–17 at 0xE0–0xE7;
  - pins 20–25 at 0xE8–0xED;
  - pins 30–37 at 0xF5–0xFC.
  A read of any other setup address, except 0x03, returns 0x00.
- R7: Setup byte layout. Bit 0 = 1 makes the pin an input. Bit 1 = 1 inverts its polarity. Bit 3 = 1 hands it to the alternate function. Bits 2 and 7:4 are not stored and read as 0.
- R8: An output pin (bit 0 = 0, bit 3 = 0) has its pad enable set. It drives its data latch bit, complemented when bit 1 is set. An input pin that is not in special mode has its pad enable clear. Pad signals change one clock after the setup or data write.
- R9: Data readback:
  - an input pin returns its synchronized pad level, complemented when bit 1 is set;
  - an output pin returns its latch bit.
- R10: A pin in special mode drives its pad enable and pad output from its alternate-function enable and output, registered once. A data read returns the synchronized pad level, complemented when bit 1 is set.
- R11: The alternate-function input of every pin carries that pin's pad level after SYNC_STAGES clocks, whatever the pin's mode.
- R12: Read timing. A read strobe updates the matching read-data port at the next clock edge. Each port holds its value until the next read strobe on that path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Setup path write strobe |
| cfg_rd | input | 1 | Setup path read strobe |
| cfg_addr | input | 8 | Setup path address |
| cfg_wdata | input | 8 | Setup path write data |
| cfg_rdata | output | 8 | Setup path read data, registered |
| io_wr | input | 1 | I/O path write strobe |
| io_rd | input | 1 | I/O path read strobe |
| io_addr | input | 8 | I/O path address |
| io_wdata | input | 8 | I/O path write data |
| io_rdata | output | 8 | I/O path read data, registered |
| pad_in | input | 22 | Pad input levels, flat pin order 10–17, 20–25, 30–37 |
| pad_out | output | 22 | Pad output values |
| pad_oe | output | 22 | Pad output enables |
| alt_out | input | 22 | Alternate-function output values |
| alt_oe | input | 22 | Alternate-function output enables |
| alt_in | output | 22 | Synchronized pad levels to the alternate functions |

## Verification
The bench targets these failure modes:
- **Sparse six-pin group.** A design that stores or returns data bits 7:6 would read 0xFF back instead of 0x3F.
- **Relocation and gating.** The pair is moved between address sets, and accesses are made while it is disabled. A wrong base table, or a write that leaks through while gated, shows up as a wrong latch value on a later enabled read.
- **Polarity inversion.** Inversion is checked separately on driven outputs, on sampled inputs and on special-mode pins. A design that inverts in only one direction, or also inverts the latch readback of an output pin, gives a mismatched bit.
- **Cycle-accurate behavioural model.** Random setup and port traffic is compared against a behavioural model on every clock. A design that adds or drops a register stage in the synchronizer or the pad path then disagrees on the exact cycle.

// File: rtl/gmux_pkg.sv
package gmux_pkg;

  typedef struct packed {
    logic spc;
    logic inv;
    logic inp;
  } pin_cfg_t;

  localparam logic [7:0] CFG_BYTE_MASK  = 8'h0B;
  localparam logic [7:0] CFG_BYTE_RESET = 8'h01;
  localparam logic [7:0] SEL_BYTE_MASK  = 8'h83;

  function automatic logic [7:0] pair_index_addr(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8'hE0;
      2'd1:    return 8'hE2;
      2'd2:    return 8'hE4;
      default: return 8'hEA;
    endcase
  endfunction

  function automatic pin_cfg_t cfg_from_byte(input logic [7:0] b);
    pin_cfg_t c;
    c.spc = b[3];
    c.inv = b[1];
    c.inp = b[0];
    return c;
  endfunction

endpackage

// File: rtl/gmux_sync.sv
module gmux_sync #(
  parameter int W      = 22,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/gmux_cfg_regs.sv
module gmux_cfg_regs
  import gmux_pkg::*;
#(
  parameter int NPIN     = 22,
  parameter int A_W      = 8,
  parameter int B_W      = 6,
  parameter int BASE_A   = 'hE0,
  parameter int BASE_B   = 'hE8,
  parameter int BASE_C   = 'hF5,
  parameter int SEL_ADDR = 'h03
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_wr,
  input  logic                 cfg_rd,
  input  logic [7:0]           cfg_addr,
  input  logic [7:0]           cfg_wdata,
  output logic [7:0]           cfg_rdata,
  output logic                 sel_en,
  output logic [1:0]           sel_pair,
  output pin_cfg_t [NPIN-1:0]  pin_cfg
);

  localparam logic [7:0] SEL_A = 8'(SEL_ADDR);

  logic [7:0] sel_q;
  logic [7:0] cfg_q [NPIN];
  logic [7:0] rd_mux;

  function automatic logic [7:0] pin_addr(input int p);
    if (p < A_W)            return 8'(BASE_A + p);
    else if (p < A_W + B_W) return 8'(BASE_B + p - A_W);
    else                    return 8'(BASE_C + p - A_W - B_W);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      for (int p = 0; p < NPIN; p++) cfg_q[p] <= CFG_BYTE_RESET;
    end else if (cfg_wr) begin
      if (cfg_addr == SEL_A) sel_q <= cfg_wdata & SEL_BYTE_MASK;
      for (int p = 0; p < NPIN; p++)
        if (cfg_addr == pin_addr(p)) cfg_q[p] <= cfg_wdata & CFG_BYTE_MASK;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (cfg_addr == SEL_A) rd_mux = sel_q;
    for (int p = 0; p < NPIN; p++)
      if (cfg_addr == pin_addr(p)) rd_mux = rd_mux | cfg_q[p];
  end

  always_ff @(posedge clk) begin
    if (rst)         cfg_rdata <= '0;
    else if (cfg_rd) cfg_rdata <= rd_mux;
  end

  always_comb begin
    for (int p = 0; p < NPIN; p++) pin_cfg[p] = cfg_from_byte(cfg_q[p]);
  end

  assign sel_en   = sel_q[7];
  assign sel_pair = sel_q[1:0];

  // R2: a relocation write lands in the enable and pair outputs
  assert_sel_write_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_addr == SEL_A) |=>
      (sel_en == $past(cfg_wdata[7]) && sel_pair == $past(cfg_wdata[1:0])));

  // R7: unstored setup bits always read back as zero
  assert_unused_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd && cfg_addr != SEL_A) |=> (cfg_rdata[7:4] == 4'd0 && cfg_rdata[2] == 1'b0));

  // R12: read data only moves on a read strobe
  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !cfg_rd |=> $stable(cfg_rdata));

endmodule

// File: rtl/gmux_port.sv
module gmux_port
  import gmux_pkg::*;
#(
  parameter int NPIN = 22,
  parameter int A_W  = 8,
  parameter int B_W  = 6,
  parameter int C_W  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            io_wr,
  input  logic            io_rd,
  input  logic [7:0]      io_addr,
  input  logic [7:0]      io_wdata,
  output logic [7:0]      io_rdata,
  input  logic            sel_en,
  input  logic [1:0]      sel_pair,
  input  logic [NPIN-1:0] rd_bits,
  output logic [NPIN-1:0] latch
);

  localparam int B_LO = A_W;
  localparam int C_LO = A_W + B_W;

  logic [7:0] base;
  logic       idx_hit;
  logic       dat_hit;
  logic [7:0] index_q;
  logic [7:0] grp_val;
  logic [7:0] rd_mux;

  assign base    = pair_index_addr(sel_pair);
  assign idx_hit = sel_en && (io_addr == base);
  assign dat_hit = sel_en && (io_addr == base + 8'd1);

  always_comb begin
    grp_val = '0;
    case (index_q)
      8'd1: grp_val[A_W-1:0] = rd_bits[B_LO-1:0];
      8'd2: grp_val[B_W-1:0] = rd_bits[C_LO-1:B_LO];
      8'd3: grp_val[C_W-1:0] = rd_bits[NPIN-1:C_LO];
      default: grp_val = '0;
    endcase
  end

  always_comb begin
    if (idx_hit)      rd_mux = index_q;
    else if (dat_hit) rd_mux = grp_val;
    else              rd_mux = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      index_q  <= '0;
      latch    <= '0;
      io_rdata <= '0;
    end else begin
      if (io_rd) io_rdata <= rd_mux;
      if (io_wr && idx_hit) index_q <= io_wdata;
      if (io_wr && dat_hit) begin
        case (index_q)
          8'd1: latch[B_LO-1:0]    <= io_wdata[A_W-1:0];
          8'd2: latch[C_LO-1:B_LO] <= io_wdata[B_W-1:0];
          8'd3: latch[NPIN-1:C_LO] <= io_wdata[C_W-1:0];
          default: ;
        endcase
      end
    end
  end

  // R3: a gated write leaves the latches alone
  assert_gated_write_R3: assert property (@(posedge clk) disable iff (rst)
    (io_wr && !sel_en) |=> $stable(latch));

  // R3: a gated read returns all ones
  assert_gated_read_R3: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !sel_en) |=> (io_rdata == 8'hFF));

  // R4: data writes under an unmapped index change nothing
  assert_bad_index_R4: assert property (@(posedge clk) disable iff (rst)
    (io_wr && dat_hit && (index_q == 8'd0 || index_q > 8'd3)) |=> $stable(latch));

  generate
    if (B_W < 8) begin : g_sparse
      // R5: top bits of the short group read as zero
      assert_short_group_R5: assert property (@(posedge clk) disable iff (rst)
        (io_rd && dat_hit && index_q == 8'd2) |=> (io_rdata[7:B_W] == '0));
    end
  endgenerate

endmodule

// File: rtl/gmux_pin.sv
module gmux_pin
  import gmux_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  pin_cfg_t cfg,
  input  logic     lat,
  input  logic     pad_s,
  input  logic     alt_out,
  input  logic     alt_oe,
  output logic     pad_out,
  output logic     pad_oe,
  output logic     rd_bit
);

  assign rd_bit = (cfg.inp || cfg.spc) ? (pad_s ^ cfg.inv) : lat;

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= 1'b0;
      pad_oe  <= 1'b0;
    end else if (cfg.spc) begin
      pad_out <= alt_out;
      pad_oe  <= alt_oe;
    end else begin
      pad_out <= lat ^ cfg.inv;
      pad_oe  <= ~cfg.inp;
    end
  end

  // R10: special mode forwards the peripheral's drive one clock later
  assert_special_follow_R10: assert property (@(posedge clk) disable iff (rst)
    cfg.spc |=> (pad_oe == $past(alt_oe) && pad_out == $past(alt_out)));

  // R8: a plain input never drives its pad
  assert_input_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg.inp && !cfg.spc) |=> !pad_oe);

  // R8: a plain output drives with its enable set
  assert_output_drive_R8: assert property (@(posedge clk) disable iff (rst)
    (!cfg.inp && !cfg.spc) |=> pad_oe);

endmodule

// File: rtl/gmux_gpio.sv
module gmux_gpio
  import gmux_pkg::*;
#(
  parameter int GRP_A_W     = 8,
  parameter int GRP_B_W     = 6,
  parameter int GRP_C_W     = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CFG_SEL     = 'h03,
  parameter int CFG_BASE_A  = 'hE0,
  parameter int CFG_BASE_B  = 'hE8,
  parameter int CFG_BASE_C  = 'hF5,
  localparam int NPIN       = GRP_A_W + GRP_B_W + GRP_C_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_wr,
  input  logic            cfg_rd,
  input  logic [7:0]      cfg_addr,
  input  logic [7:0]      cfg_wdata,
  output logic [7:0]      cfg_rdata,
  input  logic            io_wr,
  input  logic            io_rd,
  input  logic [7:0]      io_addr,
  input  logic [7:0]      io_wdata,
  output logic [7:0]      io_rdata,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  input  logic [NPIN-1:0] alt_out,
  input  logic [NPIN-1:0] alt_oe,
  output logic [NPIN-1:0] alt_in
);

  logic                sel_en;
  logic [1:0]          sel_pair;
  pin_cfg_t [NPIN-1:0] pin_cfg;
  logic [NPIN-1:0]     latch;
  logic [NPIN-1:0]     rd_bits;
  logic [NPIN-1:0]     pad_s;

  gmux_cfg_regs #(
    .NPIN(NPIN), .A_W(GRP_A_W), .B_W(GRP_B_W),
    .BASE_A(CFG_BASE_A), .BASE_B(CFG_BASE_B), .BASE_C(CFG_BASE_C),
    .SEL_ADDR(CFG_SEL)
  ) u_cfg (
    .clk(clk), .rst(rst),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .sel_en(sel_en), .sel_pair(sel_pair), .pin_cfg(pin_cfg)
  );

  gmux_port #(
    .NPIN(NPIN), .A_W(GRP_A_W), .B_W(GRP_B_W), .C_W(GRP_C_W)
  ) u_port (
    .clk(clk), .rst(rst),
    .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata),
    .sel_en(sel_en), .sel_pair(sel_pair),
    .rd_bits(rd_bits), .latch(latch)
  );

  gmux_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pad_s)
  );

  assign alt_in = pad_s;

  generate
    for (genvar p = 0; p < NPIN; p++) begin : g_pin
      gmux_pin u_pin (
        .clk(clk), .rst(rst),
        .cfg(pin_cfg[p]), .lat(latch[p]), .pad_s(pad_s[p]),
        .alt_out(alt_out[p]), .alt_oe(alt_oe[p]),
        .pad_out(pad_out[p]), .pad_oe(pad_oe[p]), .rd_bit(rd_bits[p])
      );
    end
  endgenerate

endmodule

// File: tb/gmux_gpio_bench.sv
`timescale 1ns/1ps
module gmux_gpio_bench;

  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 0, cfg_rd = 0, io_wr = 0, io_rd = 0;
  logic [7:0] cfg_addr = 0, cfg_wdata = 0, io_addr = 0, io_wdata = 0;
  logic [7:0] cfg_rdata, io_rdata;
  logic [21:0] pad_in = 0, alt_out = 0, alt_oe = 0;
  logic [21:0] pad_out, pad_oe, alt_in;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit started = 0;

  always #2 clk = ~clk;

  gmux_gpio u_gmux_gpio (
    .clk(clk), .rst(rst),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit         m_en;
  bit [1:0]   m_pair;
  bit [21:0]  m_inp, m_inv, m_spc, m_lat;
  bit [7:0]   m_idx;
  bit [21:0]  m_q[$];
  bit [21:0]  m_pout, m_poe;
  bit [7:0]   m_ior, m_cfr;

  function automatic int cfg_pin(input bit [7:0] a);
    if (a >= 8'hE0 && a <= 8'hE7) return a - 8'hE0;
    if (a >= 8'hE8 && a <= 8'hED) return 8 + a - 8'hE8;
    if (a >= 8'hF5 && a <= 8'hFC) return 14 + a - 8'hF5;
    return -1;
  endfunction

  function automatic bit [7:0] pair_of(input bit [1:0] s);
    bit [7:0] t [4] = '{8'hE0, 8'hE2, 8'hE4, 8'hEA};
    return t[s];
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_en = 0; m_pair = 0; m_inp = '1; m_inv = 0; m_spc = 0; m_lat = 0; m_idx = 0;
      m_q.delete();
      for (int i = 0; i < SYNC; i++) m_q.push_back('0);
      m_pout = 0; m_poe = 0; m_ior = 0; m_cfr = 0;
    end else begin
      bit [21:0] rb;
      bit [21:0] ps;
      ps = m_q[0];
      for (int i = 0; i < 22; i++) begin
        rb[i] = (m_inp[i] || m_spc[i]) ? (ps[i] ^ m_inv[i]) : m_lat[i];
        if (m_spc[i]) begin m_poe[i] = alt_oe[i]; m_pout[i] = alt_out[i]; end
        else begin m_poe[i] = !m_inp[i]; m_pout[i] = m_lat[i] ^ m_inv[i]; end
      end
      if (cfg_rd) begin
        int p;
        p = cfg_pin(cfg_addr);
        if (cfg_addr == 8'h03) m_cfr = {m_en, 5'd0, m_pair};
        else if (p >= 0) m_cfr = {4'd0, m_spc[p], 1'b0, m_inv[p], m_inp[p]};
        else m_cfr = 8'h00;
      end
      if (io_rd) begin
        if (!m_en) m_ior = 8'hFF;
        else if (io_addr == pair_of(m_pair)) m_ior = m_idx;
        else if (io_addr == pair_of(m_pair) + 8'd1) begin
          case (m_idx)
            8'd1: m_ior = rb[7:0];
            8'd2: m_ior = {2'b00, rb[13:8]};
            8'd3: m_ior = rb[21:14];
            default: m_ior = 8'h00;
          endcase
        end else m_ior = 8'hFF;
      end
      if (io_wr && m_en) begin
        if (io_addr == pair_of(m_pair)) m_idx = io_wdata;
        else if (io_addr == pair_of(m_pair) + 8'd1) begin
          if (m_idx == 1) m_lat[7:0] = io_wdata;
          if (m_idx == 2) m_lat[13:8] = io_wdata[5:0];
          if (m_idx == 3) m_lat[21:14] = io_wdata;
        end
      end
      if (cfg_wr) begin
        int p;
        p = cfg_pin(cfg_addr);
        if (cfg_addr == 8'h03) begin m_en = cfg_wdata[7]; m_pair = cfg_wdata[1:0]; end
        if (p >= 0) begin m_spc[p] = cfg_wdata[3]; m_inv[p] = cfg_wdata[1]; m_inp[p] = cfg_wdata[0]; end
      end
      void'(m_q.pop_front());
      m_q.push_back(pad_in);
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R8 R10 pad_out model", pad_out, m_pout);
      chk("R8 R10 pad_oe model", pad_oe, m_poe);
      chk("R11 alt_in model", alt_in, m_q[0]);
      chk("R12 io_rdata model", io_rdata, m_ior);
      chk("R12 cfg_rdata model", cfg_rdata, m_cfr);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cfg_w(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
  endtask
  task automatic cfg_r(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); cfg_rd = 1; cfg_addr = a;
    @(negedge clk); cfg_rd = 0; d = cfg_rdata;
  endtask
  task automatic io_w(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); io_wr = 1; io_addr = a; io_wdata = d;
    @(negedge clk); io_wr = 0;
  endtask
  task automatic io_r(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); io_rd = 1; io_addr = a;
    @(negedge clk); io_rd = 0; d = io_rdata;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cfg_r(8'hE0, v); chk("R1 R6 pin10 setup reset", v, 8'h01);
    cfg_r(8'hF5, v); chk("R1 R6 pin30 setup reset", v, 8'h01);
    cfg_r(8'h03, v); chk("R1 relocation reset", v, 8'h00);
    chk("R1 pad_oe reset", pad_oe, 22'h0);
    cfg_r(8'h10, v); chk("R6 unmapped setup addr", v, 8'h00);
    cfg_r(8'hEE, v); chk("R6 gap setup addr", v, 8'h00);
    io_r(8'hE1, v);  chk("R3 read while gated", v, 8'hFF);

    cfg_w(8'h03, 8'hFF);
    cfg_r(8'h03, v); chk("R2 relocation masked readback", v, 8'h83);
    io_w(8'hEA, 8'h01);
    io_r(8'hEA, v);  chk("R4 index readback", v, 8'h01);
    io_w(8'hEB, 8'hA5);
    for (int p = 0; p < 8; p++) cfg_w(8'(8'hE0 + p), 8'h00);
    repeat (2) @(negedge clk);
    chk("R8 group A enables", pad_oe[7:0], 8'hFF);
    chk("R8 group A drive", pad_out[7:0], 8'hA5);
    io_r(8'hEB, v);  chk("R9 output readback", v, 8'hA5);

    cfg_w(8'hE0, 8'h02);
    repeat (2) @(negedge clk);
    chk("R8 inverted drive pin10", pad_out[0], 1'b0);
    io_r(8'hEB, v);  chk("R9 inverted output reads latch", v, 8'hA5);

    cfg_w(8'hE8, 8'hFF);
    cfg_r(8'hE8, v); chk("R7 setup byte mask", v, 8'h0B);
    for (int p = 0; p < 6; p++) cfg_w(8'(8'hE8 + p), 8'h00);
    io_w(8'hEA, 8'h02); io_w(8'hEB, 8'hFF);
    io_r(8'hEB, v);  chk("R5 short group top bits", v, 8'h3F);

    pad_in[21:14] = 8'h3C;
    repeat (4) @(negedge clk);
    chk("R11 alt_in follows pad", alt_in[21:14], 8'h3C);
    cfg_w(8'hF5, 8'h03);
    io_w(8'hEA, 8'h03);
    io_r(8'hEB, v);  chk("R9 inverted input readback", v, 8'h3D);

    io_w(8'hEA, 8'h05); io_w(8'hEB, 8'h00);
    io_r(8'hEB, v);  chk("R4 unmapped index reads zero", v, 8'h00);
    io_w(8'hEA, 8'h01);
    io_r(8'hEB, v);  chk("R4 unmapped index write ignored", v, 8'hA5);

    cfg_w(8'h03, 8'h03);
    io_w(8'hEB, 8'h00);
    io_r(8'hEB, v);  chk("R3 gated data read", v, 8'hFF);
    cfg_w(8'h03, 8'h83);
    io_r(8'hEB, v);  chk("R3 gated write ignored", v, 8'hA5);

    cfg_w(8'h03, 8'h80);
    io_r(8'hEB, v);  chk("R2 old pair gone", v, 8'hFF);
    io_w(8'hE0, 8'h01);
    io_r(8'hE1, v);  chk("R2 relocated pair", v, 8'hA5);

    alt_oe[4] = 1; alt_out[4] = 1;
    cfg_w(8'hE4, 8'h08);
    repeat (2) @(negedge clk);
    chk("R10 special drive", pad_out[4], 1'b1);
    chk("R10 special enable", pad_oe[4], 1'b1);
    alt_oe[4] = 0;
    repeat (2) @(negedge clk);
    chk("R10 special enable released", pad_oe[4], 1'b0);
    pad_in[4] = 1;
    repeat (4) @(negedge clk);
    io_r(8'hE1, v);  chk("R10 special reads pad", v, 8'hB5);
    repeat (3) @(negedge clk);
    chk("R12 read data holds", io_rdata, 8'hB5);

    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      cfg_wr    = ($urandom_range(0, 7) == 0);
      cfg_rd    = ($urandom_range(0, 3) == 0);
      cfg_addr  = ($urandom_range(0, 5) == 0) ? 8'h03 : 8'(8'hE0 + $urandom_range(0, 31));
      cfg_wdata = ($urandom_range(0, 3) == 0) ? 8'(8'h80 | $urandom_range(0, 3)) : 8'($urandom);
      io_wr     = ($urandom_range(0, 2) == 0);
      io_rd     = ($urandom_range(0, 1) == 0);
      io_addr   = 8'(8'hE0 + $urandom_range(0, 11));
      io_wdata  = ($urandom_range(0, 2) == 0) ? 8'($urandom_range(0, 4)) : 8'($urandom);
      pad_in    = 22'($urandom);
      alt_out   = 22'($urandom);
      alt_oe    = 22'($urandom);
    end
    @(negedge clk);
    cfg_wr = 0; cfg_rd = 0; io_wr = 0; io_rd = 0;
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule